// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state update that a 32-bit in-order core makes when it takes an exception, an interrupt or a break. The core presents a one-hot event request together with its current program counter, the pending branch target, its machine status word, its exception status word and three pipeline flags. The flags mark a delay slot, an immediate prefix, and a branch that carried an immediate prefix. On the next clock edge the block produces the redirected program counter and the link register write. It also produces the new status words, the captured branch target, and pulses that clear the pipeline flags and drop any load-reserved reservation.

Mode state is saved by copying the translation-enable bit and the user-mode bit one position up into shadow bits. Both live bits are then cleared, so every handler starts privileged with translation off. When a memory fault hits an instruction that sits behind a branch or an immediate prefix, the saved return address is moved back so that the whole sequence runs again.

A request that cannot be taken is rejected and causes no update. This covers two cases: more than one request bit set at once, and an interrupt raised while an exception or a break is already in progress. The error output reports both cases. A hardware exception on a core strapped without exception support is dropped silently.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The request vector `evt_req` uses bit 0 for hardware exception, bit 1 for memory fault, bit 2 for interrupt, bit 3 for software break and bit 4 for hardware break. An accepted request sets `pc_next` to 0x20 for a hardware exception or a memory fault, 0x10 for an interrupt, 0x18 for a hardware break, and `br_tgt` for a software break.
- R2: The link write goes to index 17 with `cur_pc`+4 on a hardware exception, to index 14 with `cur_pc` on an interrupt, and to index 16 with `cur_pc` on a hardware break. A software break makes no link write (`link_we`=0).
- R3: A memory fault writes index 17 with `cur_pc` when neither flag is set. The value is `cur_pc`-4 when only the delay-slot flag is set or only the immediate flag is set, and `cur_pc`-8 when both the delay-slot flag and the prefixed-branch flag are set.
- R4: On every accepted entry, status bit 13 (translation enable) is copied to bit 14 and bit 11 (user mode) is copied to bit 12. Bits 13 and 11 are then cleared.
- R5: Hardware exceptions and memory faults set status bit 9 (exception in progress). Both break kinds set status bit 3 (break in progress). An interrupt clears status bit 1 (interrupt enable). All other status bits pass through unchanged.
- R6: On a hardware exception or a memory fault, `esr_out` is `esr_in` with bit 12 replaced by the delay-slot flag, and `btr_out` loads `br_tgt` when that flag is set. Other events pass `esr_in` through and leave `btr_out` unchanged.
- R7: `clr_resv` pulses on every accepted entry. `clr_iflags` pulses only on hardware exceptions and memory faults.
- R8: When `cfg_exc_en` is 0, a hardware exception request causes no update: `done` stays 0 and `msr_out`, `esr_out` and `btr_out` keep their values.
- R9: `err` pulses, and no update occurs, when more than one request bit is set. The same applies when an interrupt arrives while status bit 9 or bit 3 of `msr_in` is set.
- R10: Outputs change on the clock edge that samples the request. `done` is high for exactly one cycle per accepted request, and with no request the status outputs hold.
- R11: Synchronous reset clears `msr_out`, `esr_out`, `btr_out` and all pulse outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_req | input | 5 | One-hot event request |
| cfg_exc_en | input | 1 | Core is built with hardware exception support |
| cur_pc | input | 32 | Program counter of the interrupted instruction |
| br_tgt | input | 32 | Pending branch target |
| msr_in | input | 32 | Current machine status word |
| esr_in | input | 32 | Current exception status word |
| in_dslot | input | 1 | Instruction sits in a branch delay slot |
| in_imm | input | 1 | Instruction carries an immediate prefix |
| in_bimm | input | 1 | The pending branch carried an immediate prefix |
| done | output | 1 | One-cycle pulse: an entry was taken |
| err | output | 1 | One-cycle pulse: request rejected |
| pc_next | output | 32 | Redirected program counter |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_val | output | 32 | Link register value |
| msr_out | output | 32 | Updated machine status word |
| esr_out | output | 32 | Updated exception status word |
| btr_out | output | 32 | Captured branch target |
| clr_iflags | output | 1 | Clear delay-slot and immediate flags |
| clr_resv | output | 1 | Invalidate load reservation |

## Verification
The bench uses the default parameters: a 4-byte instruction step and the vectors 0x20, 0x10 and 0x18. With these values each memory-fault return adjustment (0, 4 or 8 back) gives a distinct address, and each event kind lands on a distinct vector. The bench sets both mode bits and the interrupt-enable bit together, so a shadow copy placed at the wrong position, or a lost live bit, shows up in the same status word.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int EVT_W  = 5;

    // request vector positions
    localparam int EV_HWE_B = 0;
    localparam int EV_MMU_B = 1;
    localparam int EV_IRQ_B = 2;
    localparam int EV_SWB_B = 3;
    localparam int EV_HWB_B = 4;

    // status word bit positions; each shadow sits one above its live bit
    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_UMS = ST_UM + 1;
    localparam int ST_VM  = 13;
    localparam int ST_VMS = ST_VM + 1;

    localparam int ES_DS = 12;

    localparam logic [RIDX_W-1:0] LR_EXC = RIDX_W'(17);
    localparam logic [RIDX_W-1:0] LR_IRQ = RIDX_W'(14);
    localparam logic [RIDX_W-1:0] LR_BRK = RIDX_W'(16);

    typedef enum logic [2:0] {
        EV_NONE,
        EV_HWE,
        EV_MMU,
        EV_IRQ,
        EV_SWBRK,
        EV_HWBRK
    } evt_kind_e;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic              link_we;
        logic [RIDX_W-1:0] link_idx;
        logic [XLEN-1:0]   link_val;
    } redirect_t;

    typedef struct packed {
        logic [XLEN-1:0] msr;
        logic [XLEN-1:0] esr;
        logic            btr_we;
        logic            clr_iflags;
    } status_t;

    function automatic evt_kind_e kind_of(input logic [EVT_W-1:0] r);
        if (r[EV_HWE_B])      return EV_HWE;
        else if (r[EV_MMU_B]) return EV_MMU;
        else if (r[EV_IRQ_B]) return EV_IRQ;
        else if (r[EV_SWB_B]) return EV_SWBRK;
        else if (r[EV_HWB_B]) return EV_HWBRK;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/exc_req_check.sv
module exc_req_check
    import exc_entry_pkg::*;
(
    input  logic [EVT_W-1:0] evt_req,
    input  logic             cfg_exc_en,
    input  logic             busy_exc,
    input  logic             busy_brk,
    output logic             accept,
    output logic             reject,
    output evt_kind_e        kind
);
    logic multi;
    logic irq_nested;
    logic hwe_drop;

    always_comb begin
        multi      = ($countones(evt_req) > 1);
        irq_nested = evt_req[EV_IRQ_B] && (busy_exc || busy_brk);
        hwe_drop   = !multi && evt_req[EV_HWE_B] && !cfg_exc_en;
        reject     = multi || irq_nested;
        accept     = (|evt_req) && !reject && !hwe_drop;
        kind       = accept ? kind_of(evt_req) : EV_NONE;
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter int unsigned          INSN_BYTES = 4,
    parameter logic [XLEN-1:0]      VEC_EXC    = 32'h20,
    parameter logic [XLEN-1:0]      VEC_IRQ    = 32'h10,
    parameter logic [XLEN-1:0]      VEC_BRK    = 32'h18
) (
    input  evt_kind_e       kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] btgt,
    input  logic            dslot,
    input  logic            imm,
    input  logic            bimm,
    output redirect_t       rd
);
    localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

    logic [XLEN-1:0] back;

    always_comb begin
        if (dslot)    back = bimm ? STEP2 : STEP;
        else if (imm) back = STEP;
        else          back = '0;
    end

    always_comb begin
        rd = '0;
        unique case (kind)
            EV_HWE: begin
                rd.pc = VEC_EXC; rd.link_we = 1'b1;
                rd.link_idx = LR_EXC; rd.link_val = pc + STEP;
            end
            EV_MMU: begin
                rd.pc = VEC_EXC; rd.link_we = 1'b1;
                rd.link_idx = LR_EXC; rd.link_val = pc - back;
            end
            EV_IRQ: begin
                rd.pc = VEC_IRQ; rd.link_we = 1'b1;
                rd.link_idx = LR_IRQ; rd.link_val = pc;
            end
            EV_HWBRK: begin
                rd.pc = VEC_BRK; rd.link_we = 1'b1;
                rd.link_idx = LR_BRK; rd.link_val = pc;
            end
            EV_SWBRK: begin
                rd.pc = btgt;
            end
            default: rd = '0;
        endcase
    end

endmodule

// File: rtl/exc_status_upd.sv
module exc_status_upd
    import exc_entry_pkg::*;
(
    input  evt_kind_e       kind,
    input  logic [XLEN-1:0] msr,
    input  logic [XLEN-1:0] esr,
    input  logic            dslot,
    output status_t         st
);
    logic is_exc;
    logic is_brk;

    always_comb begin
        is_exc = (kind == EV_HWE) || (kind == EV_MMU);
        is_brk = (kind == EV_SWBRK) || (kind == EV_HWBRK);

        st.msr = msr;
        st.esr = esr;
        st.btr_we = 1'b0;
        st.clr_iflags = 1'b0;

        if (kind != EV_NONE) begin
            st.msr[ST_VMS] = msr[ST_VM];
            st.msr[ST_UMS] = msr[ST_UM];
            st.msr[ST_VM]  = 1'b0;
            st.msr[ST_UM]  = 1'b0;
        end
        if (is_exc) begin
            st.msr[ST_EIP] = 1'b1;
            st.esr[ES_DS]  = dslot;
            st.btr_we      = dslot;
            st.clr_iflags  = 1'b1;
        end
        if (is_brk) st.msr[ST_BIP] = 1'b1;
        if (kind == EV_IRQ) st.msr[ST_IE] = 1'b0;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned     INSN_BYTES = 4,
    parameter logic [XLEN-1:0] VEC_EXC    = 32'h20,
    parameter logic [XLEN-1:0] VEC_IRQ    = 32'h10,
    parameter logic [XLEN-1:0] VEC_BRK    = 32'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt_req,
    input  logic              cfg_exc_en,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   br_tgt,
    input  logic [XLEN-1:0]   msr_in,
    input  logic [XLEN-1:0]   esr_in,
    input  logic              in_dslot,
    input  logic              in_imm,
    input  logic              in_bimm,
    output logic              done,
    output logic              err,
    output logic [XLEN-1:0]   pc_next,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val,
    output logic [XLEN-1:0]   msr_out,
    output logic [XLEN-1:0]   esr_out,
    output logic [XLEN-1:0]   btr_out,
    output logic              clr_iflags,
    output logic              clr_resv
);
    logic      accept;
    logic      reject;
    evt_kind_e kind;
    redirect_t rd;
    status_t   st;

    exc_req_check u_check (
        .evt_req    (evt_req),
        .cfg_exc_en (cfg_exc_en),
        .busy_exc   (msr_in[ST_EIP]),
        .busy_brk   (msr_in[ST_BIP]),
        .accept     (accept),
        .reject     (reject),
        .kind       (kind)
    );

    exc_vector_sel #(
        .INSN_BYTES (INSN_BYTES),
        .VEC_EXC    (VEC_EXC),
        .VEC_IRQ    (VEC_IRQ),
        .VEC_BRK    (VEC_BRK)
    ) u_vec (
        .kind  (kind),
        .pc    (cur_pc),
        .btgt  (br_tgt),
        .dslot (in_dslot),
        .imm   (in_imm),
        .bimm  (in_bimm),
        .rd    (rd)
    );

    exc_status_upd u_stat (
        .kind  (kind),
        .msr   (msr_in),
        .esr   (esr_in),
        .dslot (in_dslot),
        .st    (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            err        <= 1'b0;
            pc_next    <= '0;
            link_we    <= 1'b0;
            link_idx   <= '0;
            link_val   <= '0;
            msr_out    <= '0;
            esr_out    <= '0;
            btr_out    <= '0;
            clr_iflags <= 1'b0;
            clr_resv   <= 1'b0;
        end else begin
            done       <= accept;
            err        <= reject;
            link_we    <= accept && rd.link_we;
            clr_iflags <= accept && st.clr_iflags;
            clr_resv   <= accept;
            if (accept) begin
                pc_next  <= rd.pc;
                link_idx <= rd.link_idx;
                link_val <= rd.link_val;
                msr_out  <= st.msr;
                esr_out  <= st.esr;
                if (st.btr_we) btr_out <= br_tgt;
            end
        end
    end

    // accepted and rejected are exclusive outcomes
    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // handler always starts privileged with translation off
    assert_mode_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!msr_out[ST_VM] && !msr_out[ST_UM]));

    // an interrupt entry never leaves interrupts enabled
    assert_irq_masks_R5: assert property (@(posedge clk) disable iff (rst)
        (done && link_we && link_idx == LR_IRQ) |-> !msr_out[ST_IE]);

    // exception-vector entries mark exception in progress
    assert_exc_marks_R5: assert property (@(posedge clk) disable iff (rst)
        (done && pc_next == VEC_EXC && link_idx == LR_EXC) |-> msr_out[ST_EIP]);

    // an idle cycle leaves the status outputs untouched
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (evt_req == '0) |=> ($stable(msr_out) && $stable(esr_out) && $stable(btr_out) && !done));

    // a rejected request raises no entry strobe
    assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> (!clr_resv && !link_we));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    localparam int CLK_P = 10;

    localparam int IE = 1, BIP = 3, EIP = 9, UM = 11, UMS = 12, VM = 13, VMS = 14;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  evt_req;
    logic        cfg_exc_en;
    logic [31:0] cur_pc, br_tgt, msr_in, esr_in;
    logic        in_dslot, in_imm, in_bimm;
    logic        done, err, link_we, clr_iflags, clr_resv;
    logic [31:0] pc_next, link_val, msr_out, esr_out, btr_out;
    logic [4:0]  link_idx;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst(rst), .evt_req(evt_req), .cfg_exc_en(cfg_exc_en),
        .cur_pc(cur_pc), .br_tgt(br_tgt), .msr_in(msr_in), .esr_in(esr_in),
        .in_dslot(in_dslot), .in_imm(in_imm), .in_bimm(in_bimm),
        .done(done), .err(err), .pc_next(pc_next), .link_we(link_we),
        .link_idx(link_idx), .link_val(link_val), .msr_out(msr_out),
        .esr_out(esr_out), .btr_out(btr_out), .clr_iflags(clr_iflags),
        .clr_resv(clr_resv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample after the next rising edge
    task automatic fire(input logic [4:0] ev, input logic [31:0] pc, input logic [31:0] bt,
                        input logic [31:0] msr, input logic [31:0] esr,
                        input logic ds, input logic im, input logic bi);
        @(negedge clk);
        evt_req = ev; cur_pc = pc; br_tgt = bt; msr_in = msr; esr_in = esr;
        in_dslot = ds; in_imm = im; in_bimm = bi;
        @(negedge clk);
        evt_req = '0;
    endtask

    task automatic t_reset;
        chk("R11 msr_out", msr_out, 32'h0);
        chk("R11 esr_out", esr_out, 32'h0);
        chk("R11 btr_out", btr_out, 32'h0);
        chk("R11 pulses", {27'b0, done, err, link_we, clr_iflags, clr_resv}, 32'h0);
    endtask

    task automatic t_hwe;
        logic [31:0] m;
        m = (1 << VM) | (1 << UM) | (1 << IE);
        fire(5'b00001, 32'h1000, 32'h5550, m, 32'h0000_1008, 1'b0, 1'b0, 1'b0);
        chk("R1 hwe pc", pc_next, 32'h20);
        chk("R2 hwe link", {27'b0, link_idx}, 32'd17);
        chk("R2 hwe val", link_val, 32'h1004);
        chk("R4 R5 hwe msr", msr_out, (1 << VMS) | (1 << UMS) | (1 << IE) | (1 << EIP));
        chk("R6 hwe esr", esr_out, 32'h0000_0008);
        chk("R6 hwe btr hold", btr_out, 32'h0);
        chk("R7 hwe pulses", {30'b0, clr_iflags, clr_resv}, 32'h3);
        chk("R10 hwe done", {31'b0, done}, 32'h1);
        @(negedge clk);
        chk("R10 done one cycle", {31'b0, done}, 32'h0);
        chk("R10 hold msr", msr_out, (1 << VMS) | (1 << UMS) | (1 << IE) | (1 << EIP));
    endtask

    task automatic t_hwe_dslot;
        fire(5'b00001, 32'h2000, 32'h7770, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        chk("R6 dslot esr", esr_out, 32'h0000_1000);
        chk("R6 dslot btr", btr_out, 32'h7770);
        chk("R2 dslot hwe val", link_val, 32'h2004);
    endtask

    task automatic t_mmu;
        fire(5'b00010, 32'h3000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R3 mmu plain", link_val, 32'h3000);
        chk("R1 mmu pc", pc_next, 32'h20);
        fire(5'b00010, 32'h3000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
        chk("R3 mmu imm", link_val, 32'h2FFC);
        fire(5'b00010, 32'h3000, 32'h4440, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        chk("R3 mmu dslot", link_val, 32'h2FFC);
        fire(5'b00010, 32'h3000, 32'h4440, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1);
        chk("R3 mmu dslot bimm", link_val, 32'h2FF8);
        chk("R6 mmu btr", btr_out, 32'h4440);
        chk("R5 mmu eip", msr_out, 32'h1 << EIP);
    endtask

    task automatic t_irq;
        logic [31:0] m;
        m = (1 << VM) | (1 << IE);
        fire(5'b00100, 32'h4000, 32'h9990, m, 32'h0000_1005, 1'b0, 1'b0, 1'b0);
        chk("R1 irq pc", pc_next, 32'h10);
        chk("R2 irq link", {27'b0, link_idx}, 32'd14);
        chk("R2 irq val", link_val, 32'h4000);
        chk("R5 irq msr", msr_out, 32'h1 << VMS);
        chk("R6 irq esr pass", esr_out, 32'h0000_1005);
        chk("R7 irq pulses", {30'b0, clr_iflags, clr_resv}, 32'h1);
    endtask

    task automatic t_breaks;
        fire(5'b01000, 32'h5000, 32'h6660, 32'h1 << UM, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R1 swbrk pc", pc_next, 32'h6660);
        chk("R2 swbrk no link", {31'b0, link_we}, 32'h0);
        chk("R5 swbrk msr", msr_out, (1 << UMS) | (1 << BIP));
        fire(5'b10000, 32'h5100, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R1 hwbrk pc", pc_next, 32'h18);
        chk("R2 hwbrk link", {27'b0, link_idx}, 32'd16);
        chk("R2 hwbrk val", link_val, 32'h5100);
        chk("R5 hwbrk msr", msr_out, 32'h1 << BIP);
    endtask

    task automatic t_reject;
        logic [31:0] keep;
        keep = msr_out;
        cfg_exc_en = 1'b0;
        fire(5'b00001, 32'h6000, 32'h1230, 32'hFFFF_0000, 32'h0, 1'b1, 1'b0, 1'b0);
        chk("R8 drop done", {31'b0, done}, 32'h0);
        chk("R8 drop msr", msr_out, keep);
        chk("R8 drop btr", btr_out, 32'h4440);
        cfg_exc_en = 1'b1;
        fire(5'b00011, 32'h6000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R9 multi err", {30'b0, err, done}, 32'h2);
        chk("R9 multi msr", msr_out, keep);
        fire(5'b00100, 32'h6000, 32'h0, (1 << EIP) | (1 << IE), 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R9 nested irq err", {30'b0, err, done}, 32'h2);
        fire(5'b00100, 32'h6000, 32'h0, (1 << BIP) | (1 << IE), 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R9 irq in break err", {30'b0, err, done}, 32'h2);
        chk("R9 irq in break msr", msr_out, keep);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; evt_req = '0; cfg_exc_en = 1'b1;
        cur_pc = '0; br_tgt = '0; msr_in = '0; esr_in = '0;
        in_dslot = 1'b0; in_imm = 1'b0; in_bimm = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hwe();
        t_hwe_dslot();
        t_mmu();
        t_irq();
        t_breaks();
        t_reject();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule